// File: doc/BRIEF.md
# Processor Core Timer Facility

This block holds the timing resources of an embedded processor core. A 64-bit time base counts ticks that come either from a programmable divider of the core clock or from rising edges of an external tick input. Three timers hang off that one time base. A decrementer counts down and can reload itself. A fixed-interval timer and a watchdog each fire when a chosen time-base bit goes from 0 to 1. A separate 64-bit alternate time base counts every core clock. The watchdog works in two stages: its first expiry raises an interrupt, and a second expiry before software has cleared the first raises a reset request.

Software reaches the block through a plain synchronous register port: a 3-bit word address, a write enable, 32-bit write data and combinational read data. Sticky event flags sit in a status word that software clears by writing ones. While the debug-freeze input is high, every counter in the block holds its value.

Top module: `core_tmr_top`

## Requirements
- R1: After reset every register reads zero: time base, decrementer, reload value, control and status. All four request outputs are low.
- R2: The time base advances by one on each tick. With control bit 9 low, a tick comes on every (D+1)-th unfrozen core cycle, where D is control bits 17:10. With bit 9 high, a tick comes on each cycle where ext_tick is high and was low on the previous cycle.
- R3: A write to address 0 (low half) or address 1 (high half) of the time base shows in the next cycle. The time base does not also increment in that cycle. A carry out of the low half reaches the high half.
- R4: The decrementer (address 2) drops by one on each tick and holds at zero. On a tick where it is 1 and it is not being written, it expires and sets status bit 0. On expiry it loads the reload value (address 3) when control bit 1 is set, and otherwise goes to 0.
- R5: The fixed-interval event fires when time-base bit 2, 4, 6 or 8 (chosen by control bits 6:5 = 0..3) rises from 0 to 1 through counting. Time-base writes never fire it. The event sets status bit 1.
- R6: The watchdog event uses bit 3, 5, 7 or 9 (chosen by control bits 8:7) in the same way. It sets status bit 2. When status bit 2 is already set and control bit 4 is set, the event also makes wdt_reset_req high for exactly the following cycle.
- R7: dec_irq, fit_irq and wdt_irq equal status bits 0, 1 and 2, each ANDed with its enable in control bits 0, 2 and 3.
- R8: Writing address 5 clears each status bit written as one and leaves bits written as zero unchanged. An event in the same cycle wins over the clear.
- R9: While dbg_freeze is high, the time base, the alternate time base, the decrementer and the tick divider all hold.
- R10: The alternate time base (addresses 6 and 7) increments on every unfrozen core cycle. Writes to it are ignored.
- R11: Reload (address 3) and control (address 4, bits 17:0) read back what was written. Unused read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | External time-base tick, edge detected |
| dbg_freeze | input | 1 | Holds all counters while high |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| dec_irq | output | 1 | Decrementer interrupt request |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| wdt_irq | output | 1 | Watchdog critical interrupt request |
| wdt_reset_req | output | 1 | Watchdog second-stage reset request |

## Verification
The assertions assume that ext_tick and dbg_freeze are synchronous to clk. They also assume that no time-base write comes in the same cycle as a tick whose increment they check, so every counter step they check is made under a known write strobe. The bench drives all inputs at the falling edge, which keeps them synchronous. It writes the time base only through the register port, and the assertions exclude those write cycles from the increment checks. The divider is kept at small values so that tap transitions, decrementer expiries and second watchdog expiries all occur many times within the run.

// File: rtl/core_tmr_pkg.sv
package core_tmr_pkg;

  localparam int PRESC_W = 8;
  localparam int TAP_W   = 8;
  localparam int ST_DEC  = 0;
  localparam int ST_FIT  = 1;
  localparam int ST_WDT  = 2;
  localparam int ST_W    = 3;

  typedef struct packed {
    logic [PRESC_W-1:0] div;         // 17:10 tick divider
    logic               tick_ext;    // 9     tick from external input
    logic [1:0]         wdt_sel;     // 8:7
    logic [1:0]         fit_sel;     // 6:5
    logic               wdt_rst_en;  // 4
    logic               wdt_ie;      // 3
    logic               fit_ie;      // 2
    logic               dec_reload;  // 1
    logic               dec_ie;      // 0
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  typedef enum logic [2:0] {
    A_TB_LO  = 3'd0,
    A_TB_HI  = 3'd1,
    A_DEC    = 3'd2,
    A_RELOAD = 3'd3,
    A_CTRL   = 3'd4,
    A_STAT   = 3'd5,
    A_ALT_LO = 3'd6,
    A_ALT_HI = 3'd7
  } tmr_addr_e;

  function automatic int tap_pick(input logic [4*TAP_W-1:0] taps, input logic [1:0] sel);
    return int'(taps[int'(sel)*TAP_W +: TAP_W]);
  endfunction

  function automatic logic [ST_W-1:0] w1c_merge(input logic [ST_W-1:0] cur,
                                                input logic [ST_W-1:0] clr,
                                                input logic [ST_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             use_ext,
  input  logic             ext_in,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic             ext_q;
  logic [DIV_W-1:0] cnt_q;
  logic             div_hit;

  assign div_hit = (cnt_q >= div);

  always_comb begin
    if (freeze)       tick = 1'b0;
    else if (use_ext) tick = ext_in & ~ext_q;
    else              tick = div_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ext_q <= ext_in;
      if (!freeze) begin
        if (use_ext || div_hit) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W        = 64,
  parameter int HALF     = 32,
  parameter bit WRITABLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HALF-1:0] wdata,
  output logic [W-1:0]    value
);
  generate
    if (WRITABLE) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (wr_lo)  value[HALF-1:0] <= wdata;
        else if (wr_hi)  value[W-1:HALF] <= wdata[W-HALF-1:0];
        else if (adv)    value <= value + 1'b1;
      end
    end else begin : g_ro
      logic unused_wr;
      assign unused_wr = ^{wr_lo, wr_hi, wdata};
      always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (adv) value <= value + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_tap_event.sv
module tmr_tap_event #(
  parameter int                              W    = 64,
  parameter logic [4*core_tmr_pkg::TAP_W-1:0] TAPS = {8'd8, 8'd6, 8'd4, 8'd2}
) (
  input  logic [W-1:0] cur,
  input  logic         adv,
  input  logic [1:0]   sel,
  output logic         ev
);
  function automatic logic bit_rises(input logic [W-1:0] v, input int pos);
    logic [W-1:0] nxt;
    nxt = v + 1'b1;
    return ~v[pos] & nxt[pos];
  endfunction

  assign ev = adv & bit_rises(cur, core_tmr_pkg::tap_pick(TAPS, sel));
endmodule

// File: rtl/tmr_decrementer.sv
module tmr_decrementer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         reload_en,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] value,
  output logic         expire
);
  function automatic logic [W-1:0] dec_next(input logic [W-1:0] v, input logic tk,
                                            input logic ex, input logic rl_en,
                                            input logic [W-1:0] rl);
    if (ex)                 return rl_en ? rl : '0;
    if (tk && (v != '0))    return v - 1'b1;
    return v;
  endfunction

  assign expire = tick & ~wr & (value == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)  value <= '0;
    else if (wr) value <= wdata;
    else         value <= dec_next(value, tick, expire, reload_en, reload_val);
  end
endmodule

// File: rtl/core_tmr_top.sv
module core_tmr_top #(
  parameter int                               BUS_W    = 32,
  parameter logic [4*core_tmr_pkg::TAP_W-1:0] FIT_TAPS = {8'd8, 8'd6, 8'd4, 8'd2},
  parameter logic [4*core_tmr_pkg::TAP_W-1:0] WDT_TAPS = {8'd9, 8'd7, 8'd5, 8'd3}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_tick,
  input  logic             dbg_freeze,
  input  logic [2:0]       bus_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             dec_irq,
  output logic             fit_irq,
  output logic             wdt_irq,
  output logic             wdt_reset_req
);
  import core_tmr_pkg::*;

  localparam int TB_W  = 2 * BUS_W;
  localparam int DEC_W = BUS_W;

  tmr_ctrl_t          ctrl_q;
  logic [DEC_W-1:0]   reload_q;
  logic [ST_W-1:0]    sts_q;
  logic               rst_req_q;

  logic               tick;
  logic               tb_wr_lo, tb_wr_hi, tb_wr;
  logic               dec_wr, reload_wr, ctrl_wr, sts_wr;
  logic               tb_adv, alt_adv;
  logic [TB_W-1:0]    tb_val, alt_val;
  logic [DEC_W-1:0]   dec_val;
  logic               dec_exp, fit_ev, wdt_ev;
  logic [ST_W-1:0]    sts_set, sts_clr;

  // write decode
  always_comb begin
    tb_wr_lo  = bus_we && (bus_addr == A_TB_LO);
    tb_wr_hi  = bus_we && (bus_addr == A_TB_HI);
    dec_wr    = bus_we && (bus_addr == A_DEC);
    reload_wr = bus_we && (bus_addr == A_RELOAD);
    ctrl_wr   = bus_we && (bus_addr == A_CTRL);
    sts_wr    = bus_we && (bus_addr == A_STAT);
  end
  assign tb_wr   = tb_wr_lo | tb_wr_hi;
  assign tb_adv  = tick & ~tb_wr;
  assign alt_adv = ~dbg_freeze;

  tmr_tick_gen #(.DIV_W(PRESC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .freeze(dbg_freeze), .use_ext(ctrl_q.tick_ext),
    .ext_in(ext_tick), .div(ctrl_q.div), .tick(tick)
  );

  tmr_count #(.W(TB_W), .HALF(BUS_W), .WRITABLE(1'b1)) u_tb (
    .clk(clk), .rst_n(rst_n), .adv(tb_adv), .wr_lo(tb_wr_lo), .wr_hi(tb_wr_hi),
    .wdata(bus_wdata), .value(tb_val)
  );

  tmr_count #(.W(TB_W), .HALF(BUS_W), .WRITABLE(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .adv(alt_adv), .wr_lo(1'b0), .wr_hi(1'b0),
    .wdata(bus_wdata), .value(alt_val)
  );

  tmr_decrementer #(.W(DEC_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(dec_wr), .wdata(bus_wdata),
    .reload_en(ctrl_q.dec_reload), .reload_val(reload_q), .value(dec_val),
    .expire(dec_exp)
  );

  tmr_tap_event #(.W(TB_W), .TAPS(FIT_TAPS)) u_fit (
    .cur(tb_val), .adv(tb_adv), .sel(ctrl_q.fit_sel), .ev(fit_ev)
  );

  tmr_tap_event #(.W(TB_W), .TAPS(WDT_TAPS)) u_wdt (
    .cur(tb_val), .adv(tb_adv), .sel(ctrl_q.wdt_sel), .ev(wdt_ev)
  );

  // status flags and watchdog second stage
  always_comb begin
    sts_set          = '0;
    sts_set[ST_DEC]  = dec_exp;
    sts_set[ST_FIT]  = fit_ev;
    sts_set[ST_WDT]  = wdt_ev;
    sts_clr          = sts_wr ? bus_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      sts_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      if (ctrl_wr)   ctrl_q   <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (reload_wr) reload_q <= bus_wdata;
      sts_q     <= w1c_merge(sts_q, sts_clr, sts_set);
      rst_req_q <= wdt_ev & sts_q[ST_WDT] & ctrl_q.wdt_rst_en;
    end
  end

  assign dec_irq       = sts_q[ST_DEC] & ctrl_q.dec_ie;
  assign fit_irq       = sts_q[ST_FIT] & ctrl_q.fit_ie;
  assign wdt_irq       = sts_q[ST_WDT] & ctrl_q.wdt_ie;
  assign wdt_reset_req = rst_req_q;

  // read mux
  always_comb begin
    case (tmr_addr_e'(bus_addr))
      A_TB_LO:  bus_rdata = tb_val[BUS_W-1:0];
      A_TB_HI:  bus_rdata = tb_val[TB_W-1:BUS_W];
      A_DEC:    bus_rdata = dec_val;
      A_RELOAD: bus_rdata = reload_q;
      A_CTRL:   bus_rdata = BUS_W'(ctrl_q);
      A_STAT:   bus_rdata = BUS_W'(sts_q);
      A_ALT_LO: bus_rdata = alt_val[BUS_W-1:0];
      default:  bus_rdata = alt_val[TB_W-1:BUS_W];
    endcase
  end
endmodule

// File: rtl/core_tmr_chk.sv
module core_tmr_chk #(
  parameter int TB_W  = 64,
  parameter int DEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_freeze,
  input logic             tick,
  input logic             tb_wr,
  input logic             dec_wr,
  input logic [TB_W-1:0]  tb_val,
  input logic [TB_W-1:0]  alt_val,
  input logic [DEC_W-1:0] dec_val,
  input logic [2:0]       sts_q,
  input logic             dec_irq,
  input logic             fit_irq,
  input logic             wdt_irq,
  input logic             wdt_reset_req
);
  a_r2_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tb_wr) |=> (tb_val == $past(tb_val) + 1'b1));

  a_r9_tb_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_freeze && !tb_wr) |=> $stable(tb_val));

  a_r9_dec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_freeze && !dec_wr) |=> $stable(dec_val));

  a_r10_alt_step: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_freeze |=> (alt_val == $past(alt_val) + 1'b1));

  a_r4_dec_expiry_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dec_wr && dec_val == DEC_W'(1)) |=> sts_q[0]);

  a_r6_reset_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |-> $past(sts_q[2]));

  a_r6_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req);

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_irq || fit_irq || wdt_irq) |-> (sts_q != 3'b000));
endmodule

bind core_tmr_top core_tmr_chk #(.TB_W(TB_W), .DEC_W(DEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_freeze(dbg_freeze), .tick(tick), .tb_wr(tb_wr),
  .dec_wr(dec_wr), .tb_val(tb_val), .alt_val(alt_val), .dec_val(dec_val),
  .sts_q(sts_q), .dec_irq(dec_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
  .wdt_reset_req(wdt_reset_req)
);

// File: tb/tb_core_tmr_top.sv
`timescale 1ns/1ps
module tb_core_tmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        dbg_freeze = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        dec_irq, fit_irq, wdt_irq, wdt_reset_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  core_tmr_top dut (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .dbg_freeze(dbg_freeze),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dec_irq(dec_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq), .wdt_reset_req(wdt_reset_req)
  );

  // reference model state (m_ current, n_ after next edge)
  logic [63:0] m_tb = 0, n_tb = 0, m_alt = 0, n_alt = 0;
  logic [31:0] m_dec = 0, n_dec = 0, m_rl = 0, n_rl = 0;
  logic [17:0] m_ctl = 0, n_ctl = 0;
  logic [2:0]  m_sts = 0, n_sts = 0;
  logic        m_rst = 0, n_rst = 0, m_extq = 0, n_extq = 0;
  logic [7:0]  m_cnt = 0, n_cnt = 0;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_tb[31:0];
      3'd1: return m_tb[63:32];
      3'd2: return m_dec;
      3'd3: return m_rl;
      3'd4: return {14'd0, m_ctl};
      3'd5: return {29'd0, m_sts};
      3'd6: return m_alt[31:0];
      default: return m_alt[63:32];
    endcase
  endfunction

  function automatic string addr_req(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R4";
      3'd5:       return "R8";
      3'd6, 3'd7: return "R10";
      default:    return "R11";
    endcase
  endfunction

  // time-base bit rises from 0 to 1 when v counts up by one
  function automatic logic rises_at(input logic [63:0] v, input int pos);
    logic [63:0] flips;
    flips = v ^ (v + 64'd1);
    return flips[pos] && !v[pos];
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                     input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                      input logic ext, input logic frz, input string tag);
    logic tk, tbw, dexp, fev, wev;
    logic [2:0] clr;
    int fp, wp;
    string rq;
    m_tb = n_tb; m_alt = n_alt; m_dec = n_dec; m_rl = n_rl; m_ctl = n_ctl;
    m_sts = n_sts; m_rst = n_rst; m_extq = n_extq; m_cnt = n_cnt;
    bus_we = we; bus_addr = a; bus_wdata = wd; ext_tick = ext; dbg_freeze = frz;
    #1;
    rq = (tag == "") ? addr_req(a) : tag;
    chk(64'(bus_rdata), 64'(model_read(a)), rq, "read data");
    chk(64'(dec_irq), 64'(m_sts[0] & m_ctl[0]), "R7", "dec_irq");
    chk(64'(fit_irq), 64'(m_sts[1] & m_ctl[2]), "R7", "fit_irq");
    chk(64'(wdt_irq), 64'(m_sts[2] & m_ctl[3]), "R7", "wdt_irq");
    chk(64'(wdt_reset_req), 64'(m_rst), "R6", "wdt_reset_req");
    // next state from the requirements
    if (frz)           tk = 1'b0;
    else if (m_ctl[9]) tk = ext && !m_extq;
    else               tk = (m_cnt >= m_ctl[17:10]);
    if (frz)                                  n_cnt = m_cnt;
    else if (m_ctl[9] || m_cnt >= m_ctl[17:10]) n_cnt = 8'd0;
    else                                      n_cnt = m_cnt + 8'd1;
    n_extq = ext;
    tbw = we && (a == 3'd0 || a == 3'd1);
    fp = 2 + 2 * int'(m_ctl[6:5]);
    wp = 3 + 2 * int'(m_ctl[8:7]);
    fev = tk && !tbw && rises_at(m_tb, fp);
    wev = tk && !tbw && rises_at(m_tb, wp);
    if (we && a == 3'd0)      n_tb = {m_tb[63:32], wd};
    else if (we && a == 3'd1) n_tb = {wd, m_tb[31:0]};
    else                      n_tb = m_tb + (tk ? 64'd1 : 64'd0);
    n_alt = frz ? m_alt : m_alt + 64'd1;
    dexp = tk && !(we && a == 3'd2) && (m_dec == 32'd1);
    if (we && a == 3'd2)         n_dec = wd;
    else if (dexp)               n_dec = m_ctl[1] ? m_rl : 32'd0;
    else if (tk && m_dec != 0)   n_dec = m_dec - 32'd1;
    else                         n_dec = m_dec;
    n_rl  = (we && a == 3'd3) ? wd : m_rl;
    n_ctl = (we && a == 3'd4) ? wd[17:0] : m_ctl;
    clr   = (we && a == 3'd5) ? wd[2:0] : 3'd0;
    n_sts = (m_sts & ~clr) | {wev, fev, dexp};
    n_rst = wev && m_sts[2] && m_ctl[4];
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [2:0] a, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, a, 32'd0, 1'b0, 1'b0, tag);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    for (int a = 0; a < 6; a++) step(1'b0, 3'(a), 32'd0, 1'b0, 1'b0, "R1");
    // R3: time-base writes, carry into the high half
    step(1'b1, 3'd0, 32'hFFFF_FFFC, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 6; i++) step(1'b0, 3'(i % 2), 32'd0, 1'b0, 1'b0, "R3");
    step(1'b1, 3'd1, 32'h1234_5678, 1'b0, 1'b0, "R3");
    idle(2, 3'd1, "R3");
    step(1'b1, 3'd0, 32'd0, 1'b0, 1'b0, "R3");
    idle(1, 3'd0, "R3");
    // R4: decrementer with and without reload
    step(1'b1, 3'd3, 32'd5, 1'b0, 1'b0, "R11");
    step(1'b1, 3'd4, 32'h3, 1'b0, 1'b0, "R11");
    step(1'b1, 3'd2, 32'd3, 1'b0, 1'b0, "R4");
    idle(14, 3'd2, "R4");
    step(1'b1, 3'd4, 32'h1, 1'b0, 1'b0, "R4");
    idle(10, 3'd2, "R4");
    idle(2, 3'd5, "R4");
    // R8: zero write keeps flags, one write clears
    step(1'b1, 3'd5, 32'd0, 1'b0, 1'b0, "R8");
    idle(1, 3'd5, "R8");
    step(1'b1, 3'd5, 32'h7, 1'b0, 1'b0, "R8");
    idle(1, 3'd5, "R8");
    // R9: freeze holds every counter
    step(1'b1, 3'd2, 32'd20, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 9; i++) step(1'b0, 3'(i % 3 == 0 ? 0 : (i % 3 == 1 ? 6 : 2)), 32'd0, 1'b0, 1'b1, "R9");
    idle(2, 3'd2, "R9");
    // R10: alternate time base ignores writes
    step(1'b1, 3'd6, 32'hDEAD_BEEF, 1'b0, 1'b0, "R10");
    step(1'b1, 3'd7, 32'hDEAD_BEEF, 1'b0, 1'b0, "R10");
    idle(2, 3'd6, "R10");
    // R5: fixed-interval event on tap select 1 (bit 4)
    step(1'b1, 3'd4, 32'h0000_0024, 1'b0, 1'b0, "R5");
    idle(40, 3'd5, "R5");
    step(1'b1, 3'd5, 32'h7, 1'b0, 1'b0, "R5");
    // R6: two-stage watchdog on tap 0 (bit 3) with reset enabled
    step(1'b1, 3'd4, 32'h0000_001C, 1'b0, 1'b0, "R6");
    idle(50, 3'd5, "R6");
    // R2: external tick edges, then divider of 3
    step(1'b1, 3'd4, 32'h0000_0200, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 12; i++) step(1'b0, 3'd0, 32'd0, 1'((i % 5) < 2 ? 1 : (i % 3 == 0)), 1'b0, "R2");
    step(1'b1, 3'd4, 32'h0000_0800, 1'b0, 1'b0, "R2");
    idle(12, 3'd0, "R2");
    idle(2, 3'd4, "R11");
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic we, ext, frz;
      logic [2:0] a;
      logic [31:0] wd;
      we  = ($urandom % 100) < 15;
      a   = 3'($urandom % 8);
      ext = 1'($urandom % 2);
      frz = ($urandom % 100) < 8;
      wd  = $urandom;
      if (we && a == 3'd2) wd = $urandom % 40;
      if (we && a == 3'd4) wd = {14'd0, 6'd0, 2'($urandom % 4), 10'($urandom)};
      if (we && a == 3'd5) wd = $urandom % 8;
      if (we && a == 3'd1) wd = $urandom % 4;
      step(we, a, wd, ext, frz, "");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule